// File: doc/BRIEF.md
# Receive Character Timeout Detector

This block watches a serial receiver's holding queue and raises a timeout indication when characters have been sitting in it with nothing new arriving and no host read for four character times. The length of one character time comes from the current frame format: a start bit, five to eight data bits, an optional parity bit and one or two stop bits. Each bit lasts sixteen ticks of the oversampling baud strobe.

Two events restart the idle measurement: the receiver's strobe at the centre of each stop bit, and every host read of the receive holding register. While the queue is empty the measurement stays at zero and no timeout can appear. The timeout flag is ORed with the trigger-level data-ready condition to form one receive interrupt request. Both sources sit at the same priority and share one enable input.

Top module: `rx_timeout_det`

## Requirements
- R1: While reset is asserted, and at the first sample after reset, `to_flag` and `rx_irq` are 0.
- R2: The timeout limit is N = TICKS_PER_BIT × CHAR_TIMES × B ticks, with defaults 16 and 4, where B = 1 + (5 + `cfg_wlen`) + `cfg_parity` + (1 + `cfg_stop2`). `cfg_wlen` 0,1,2,3 selects 5,6,7,8 data bits. `to_flag` goes to 1 on the clock edge that counts the N-th tick since the last restart, and not on the edge before it.
- R3: A `stop_mid` pulse restarts the tick count at zero. A tick in the same cycle is not counted. `stop_mid` does not clear a flag that is already set.
- R4: A `rhr_rd` pulse restarts the tick count at zero and clears `to_flag` on that edge.
- R5: While `fifo_empty` is 1, the count is held at zero and `to_flag` is 0 after each edge. When the queue becomes non-empty, a full N ticks are needed before the flag rises.
- R6: `rx_irq` equals `irq_en` AND (`rx_trig` OR `to_flag`), combinationally.
- R7: Once set, `to_flag` stays 1 through ticks and stop-bit strobes until a read or an empty queue.
- R8: Only clock cycles with `tick16` high advance the count. The flag rises only on an edge where `tick16` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle strobe at sixteen times the bit rate |
| cfg_wlen | input | 2 | Data bits: 0→5, 1→6, 2→7, 3→8 |
| cfg_parity | input | 1 | 1 when a parity bit is present |
| cfg_stop2 | input | 1 | 1 for two stop bits, 0 for one |
| stop_mid | input | 1 | Strobe from the receiver at the centre of a stop bit |
| rhr_rd | input | 1 | Host read of the receive holding register |
| fifo_empty | input | 1 | Receive queue holds no characters |
| rx_trig | input | 1 | Data-ready condition (fill at or above trigger level) |
| irq_en | input | 1 | Shared enable for data-ready and timeout interrupts |
| to_flag | output | 1 | Receive timeout indication |
| rx_irq | output | 1 | Combined receive interrupt request |

## Verification
The properties assume that the strobes are synchronous single-cycle pulses and that the frame configuration stays constant while a measurement runs. The stimulus changes `cfg_wlen`, `cfg_parity` and `cfg_stop2` only in the same cycle as a restarting read. It drives every input at the falling clock edge. The properties also rely on `tick16` never being high in two consecutive cycles when the bench slows the tick rate, and the bench spaces ticks to match.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

   localparam int MIN_DATA_BITS   = 5;
   localparam int MAX_FRAME_BITS  = 12;
   localparam int FRAME_BITS_W    = 4;

   typedef logic [FRAME_BITS_W-1:0] frame_bits_t;

   function automatic frame_bits_t frame_bits(input logic [1:0] wlen,
                                              input logic       par,
                                              input logic       stop2);
      frame_bits_t b;
      b = frame_bits_t'(1)                          // start
        + frame_bits_t'(MIN_DATA_BITS) + frame_bits_t'(wlen)
        + frame_bits_t'(par)
        + frame_bits_t'(1) + frame_bits_t'(stop2);
      return b;
   endfunction

endpackage

// File: rtl/rxto_frame_len.sv
module rxto_frame_len
   import rxto_pkg::*;
#(
   parameter int TICKS_PER_BIT = 16,
   parameter int CHAR_TIMES    = 4,
   parameter int CNT_W         = 10
) (
   input  logic [1:0]       cfg_wlen,
   input  logic             cfg_parity,
   input  logic             cfg_stop2,
   output logic [CNT_W-1:0] limit
);

   localparam int PER_BIT   = TICKS_PER_BIT * CHAR_TIMES;
   localparam bit IS_POW2   = (PER_BIT & (PER_BIT - 1)) == 0;
   localparam int SHIFT     = $clog2(PER_BIT);

   frame_bits_t bits;

   always_comb bits = frame_bits(cfg_wlen, cfg_parity, cfg_stop2);

   generate
      if (IS_POW2) begin : g_shift
         always_comb limit = CNT_W'(bits) << SHIFT;
      end else begin : g_mult
         always_comb limit = CNT_W'(bits) * CNT_W'(PER_BIT);
      end
   endgenerate

endmodule

// File: rtl/rxto_counter.sv
module rxto_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick16,
   input  logic             stop_mid,
   input  logic             rhr_rd,
   input  logic             fifo_empty,
   input  logic [CNT_W-1:0] limit,
   output logic             to_flag
);

   logic [CNT_W-1:0] cnt_q;
   logic             flag_q;
   logic             restart;
   logic             clear;
   logic             advance;
   logic             reach;

   always_comb begin
      restart = stop_mid | rhr_rd | fifo_empty;
      clear   = rhr_rd | fifo_empty;
      advance = tick16 & ~flag_q & ~restart;
      reach   = advance & (cnt_q >= (limit - CNT_W'(1)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (restart)
            cnt_q <= '0;
         else if (advance)
            cnt_q <= cnt_q + CNT_W'(1);

         if (clear)
            flag_q <= 1'b0;
         else if (reach)
            flag_q <= 1'b1;
      end
   end

   assign to_flag = flag_q;

endmodule

// File: rtl/rxto_irq.sv
module rxto_irq (
   input  logic irq_en,
   input  logic rx_trig,
   input  logic to_flag,
   output logic rx_irq
);

   always_comb rx_irq = irq_en & (rx_trig | to_flag);

endmodule

// File: rtl/rx_timeout_det.sv
module rx_timeout_det
   import rxto_pkg::*;
#(
   parameter int TICKS_PER_BIT = 16,
   parameter int CHAR_TIMES    = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick16,
   input  logic [1:0] cfg_wlen,
   input  logic       cfg_parity,
   input  logic       cfg_stop2,
   input  logic       stop_mid,
   input  logic       rhr_rd,
   input  logic       fifo_empty,
   input  logic       rx_trig,
   input  logic       irq_en,
   output logic       to_flag,
   output logic       rx_irq
);

   localparam int MAX_LIMIT = MAX_FRAME_BITS * TICKS_PER_BIT * CHAR_TIMES;
   localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

   initial begin
      if (TICKS_PER_BIT < 1) $fatal(1, "TICKS_PER_BIT must be at least 1");
      if (CHAR_TIMES < 1)    $fatal(1, "CHAR_TIMES must be at least 1");
   end

   logic [CNT_W-1:0] limit;
   logic             flag;

   rxto_frame_len #(
      .TICKS_PER_BIT (TICKS_PER_BIT),
      .CHAR_TIMES    (CHAR_TIMES),
      .CNT_W         (CNT_W)
   ) u_len (
      .cfg_wlen   (cfg_wlen),
      .cfg_parity (cfg_parity),
      .cfg_stop2  (cfg_stop2),
      .limit      (limit)
   );

   rxto_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick16     (tick16),
      .stop_mid   (stop_mid),
      .rhr_rd     (rhr_rd),
      .fifo_empty (fifo_empty),
      .limit      (limit),
      .to_flag    (flag)
   );

   rxto_irq u_irq (
      .irq_en  (irq_en),
      .rx_trig (rx_trig),
      .to_flag (flag),
      .rx_irq  (rx_irq)
   );

   assign to_flag = flag;

endmodule

// File: rtl/rx_timeout_det_chk.sv
module rx_timeout_det_chk (
   input logic clk,
   input logic rst_n,
   input logic tick16,
   input logic stop_mid,
   input logic rhr_rd,
   input logic fifo_empty,
   input logic rx_trig,
   input logic irq_en,
   input logic to_flag,
   input logic rx_irq
);

   AST_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |=> !to_flag); // R5
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rhr_rd |=> !to_flag); // R4
   AST_STOP_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_mid |=> !$rose(to_flag)); // R3
   AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(to_flag) |-> $past(tick16)); // R8
   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (to_flag && !rhr_rd && !fifo_empty) |=> to_flag); // R7
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !rx_irq); // R6
   AST_IRQ_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && rx_trig) |-> rx_irq); // R6
   AST_IRQ_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && to_flag) |-> rx_irq); // R6

endmodule

bind rx_timeout_det rx_timeout_det_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick16     (tick16),
   .stop_mid   (stop_mid),
   .rhr_rd     (rhr_rd),
   .fifo_empty (fifo_empty),
   .rx_trig    (rx_trig),
   .irq_en     (irq_en),
   .to_flag    (to_flag),
   .rx_irq     (rx_irq)
);

// File: tb/rx_timeout_det_tb.sv
module rx_timeout_det_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 50000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic [1:0] cfg_wlen = 2'd0;
   logic       cfg_parity = 1'b0;
   logic       cfg_stop2 = 1'b0;
   logic       stop_mid = 1'b0;
   logic       rhr_rd = 1'b0;
   logic       fifo_empty = 1'b1;
   logic       rx_trig = 1'b0;
   logic       irq_en = 1'b0;
   logic       to_flag;
   logic       rx_irq;

   int pcnt = 0;
   int n_checks = 0;
   int n_fails = 0;
   bit done = 1'b0;

   typedef struct {
      int    cyc;
      bit    chk_irq;
      bit    flag;
      bit    irq;
      string tag;
   } exp_t;

   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) pcnt <= pcnt + 1;

   rx_timeout_det u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick16     (tick16),
      .cfg_wlen   (cfg_wlen),
      .cfg_parity (cfg_parity),
      .cfg_stop2  (cfg_stop2),
      .stop_mid   (stop_mid),
      .rhr_rd     (rhr_rd),
      .fifo_empty (fifo_empty),
      .rx_trig    (rx_trig),
      .irq_en     (irq_en),
      .to_flag    (to_flag),
      .rx_irq     (rx_irq)
   );

   // one clock: drive pulses at the falling edge for the next rising edge
   task automatic step(input bit tk, input bit stp, input bit rd, input bit emp);
      @(negedge clk);
      tick16 = tk; stop_mid = stp; rhr_rd = rd; fifo_empty = emp;
   endtask

   task automatic set_irq(input bit en, input bit trig);
      @(negedge clk);
      tick16 = 1'b0; stop_mid = 1'b0; rhr_rd = 1'b0;
      irq_en = en; rx_trig = trig;
   endtask

   // flag expected after the coming rising edge
   task automatic exp_next(input bit f, input string tag);
      sb.push_back('{cyc: pcnt + 1, chk_irq: 1'b0, flag: f, irq: 1'b0, tag: tag});
   endtask

   // flag and request expected right now, with the inputs just driven
   task automatic exp_now(input bit f, input bit irq, input string tag);
      sb.push_back('{cyc: pcnt, chk_irq: 1'b1, flag: f, irq: irq, tag: tag});
   endtask

   function automatic int limit_of(input int wl, input int par, input int s2);
      return 16 * 4 * (1 + 5 + wl + par + 1 + s2);
   endfunction

   // monitor: pops expectations and compares with the outputs
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb.size() > 0 && sb[0].cyc <= pcnt) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (to_flag !== e.flag) begin
               n_fails++;
               $display("FAIL %s cycle %0d: to_flag actual %0b expected %0b",
                        e.tag, pcnt, to_flag, e.flag);
            end
            if (e.chk_irq) begin
               n_checks++;
               if (rx_irq !== e.irq) begin
                  n_fails++;
                  $display("FAIL %s cycle %0d: rx_irq actual %0b expected %0b",
                           e.tag, pcnt, rx_irq, e.irq);
               end
            end
         end
      end
   end

   // restart by a read, then D-cycle spaced ticks up to the limit
   task automatic run_to(input int wl, input int par, input int s2,
                         input int d, input string tag);
      int n;
      n = limit_of(wl, par, s2);
      step(1'b0, 1'b0, 1'b1, 1'b0);
      cfg_wlen = 2'(wl); cfg_parity = par[0]; cfg_stop2 = s2[0];
      exp_next(1'b0, tag);
      for (int i = 1; i <= n; i++) begin
         step(1'b1, 1'b0, 1'b0, 1'b0);
         if (i == n - 1) exp_next(1'b0, tag);
         if (i == n)     exp_next(1'b1, tag);
         if (i < n) begin
            for (int k = 1; k < d; k++) begin
               step(1'b0, 1'b0, 1'b0, 1'b0);
               if (i == n - 1) exp_next(1'b0, tag);
            end
         end
      end
   endtask

   task automatic ticks(input int cnt);
      for (int i = 0; i < cnt; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      int n7;
      n7 = limit_of(0, 0, 0);
      // R1: quiet during reset
      irq_en = 1'b1;
      repeat (3) step(1'b1, 1'b0, 1'b0, 1'b0);
      exp_now(1'b0, 1'b0, "R1");
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b1, 1'b0, 1'b0, 1'b1);
      exp_next(1'b0, "R1");

      // R5: empty queue never times out
      for (int i = 0; i < 1000; i++) begin
         step(1'b1, 1'b0, 1'b0, 1'b1);
         if (i % 100 == 99) exp_next(1'b0, "R5");
      end

      // R2: 7-bit frame
      run_to(0, 0, 0, 1, "R2");

      // R7: flag survives ticks and a stop-bit strobe
      step(1'b1, 1'b1, 1'b0, 1'b0);
      exp_next(1'b1, "R7");
      ticks(20);
      exp_next(1'b1, "R7");

      // R6 with flag set
      set_irq(1'b0, 1'b0);
      exp_now(1'b1, 1'b0, "R6");
      set_irq(1'b1, 1'b0);
      exp_now(1'b1, 1'b1, "R6");

      // R4: read clears and restarts
      step(1'b0, 1'b0, 1'b1, 1'b0);
      exp_next(1'b0, "R4");
      ticks(n7 - 1);
      step(1'b0, 1'b0, 1'b1, 1'b0);
      ticks(n7 - 1);
      exp_next(1'b0, "R4");
      ticks(1);
      exp_next(1'b1, "R4");

      // R6 with flag clear
      step(1'b0, 1'b0, 1'b1, 1'b0);
      set_irq(1'b1, 1'b0);
      exp_now(1'b0, 1'b0, "R6");
      set_irq(1'b1, 1'b1);
      exp_now(1'b0, 1'b1, "R6");
      set_irq(1'b0, 1'b1);
      exp_now(1'b0, 1'b0, "R6");
      set_irq(1'b1, 1'b0);

      // R3: stop strobe with a coincident tick restarts
      step(1'b0, 1'b0, 1'b1, 1'b0);
      ticks(n7 - 1);
      step(1'b1, 1'b1, 1'b0, 1'b0);
      exp_next(1'b0, "R3");
      ticks(n7 - 1);
      exp_next(1'b0, "R3");
      ticks(1);
      exp_next(1'b1, "R3");

      // R5: empty clears, then a full period from zero
      step(1'b1, 1'b0, 1'b0, 1'b1);
      exp_next(1'b0, "R5");
      ticks(n7 - 1);
      exp_next(1'b0, "R5");
      ticks(1);
      exp_next(1'b1, "R5");

      // R2: other frame formats
      run_to(3, 1, 1, 1, "R2");
      run_to(1, 1, 0, 1, "R2");
      run_to(2, 0, 1, 1, "R2");

      // R8: ticks every third cycle
      run_to(0, 0, 0, 3, "R8");

      repeat (3) step(1'b0, 1'b0, 1'b0, 1'b0);
      if (sb.size() != 0) begin
         n_fails++;
         $display("FAIL scoreboard: %0d expectations left, expected 0", sb.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: cycles actual %0d expected fewer", WATCHDOG);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule